// File: doc/BRIEF.md
# Dual-Port Address Collision Arbiter

This block sits beside a two-port memory and watches the request of each port: an enable plus an address. When both ports are enabled on the same address, it flags exactly one of them as busy on an active-low output. The flagged port is always the one whose request showed up later. Any write that port attempts is suppressed, so the memory never takes two writes to one word in the same cycle, and a read that races a write is reported to its requester.

Arrival order is decided on clock edges. Each port's request is registered every cycle. A request counts as new in a cycle when the port was idle in the previous cycle, or when its address differs from the previous cycle's. A new request loses to one that was already present. When both requests are new in the same cycle, the tie goes to the port picked by a parameter, which is the left port by default. Once a winner is chosen, it keeps the word for as long as the collision lasts. The busy outputs are combinational from the present inputs and the held decision, so the write suppression covers every cycle of a collision, including the first.

Top module: `collision_arbiter`

## Requirements
- R1: When both ports are enabled on different addresses, `lft_busy_n` and `rgt_busy_n` are both 1.
- R2: When the addresses are equal but at least one enable is 0, both busy outputs are 1.
- R3: When one port's request was already present in the previous cycle and the other port's request is new, the busy output of the port with the new request is 0 and the other busy output is 1.
- R4: When both requests are new in the same cycle and collide, with the default `TIE_TO_LEFT = 1`, `rgt_busy_n` is 0 and `lft_busy_n` is 1.
- R5: `lft_busy_n` and `rgt_busy_n` are never 0 in the same cycle.
- R6: `*_inhibit` is the inverse of the same port's busy output. `*_we_gated` equals `*_we` when the port is not busy and is 0 when the port is busy.
- R7: While a collision continues from one cycle to the next, the same port stays busy. Both busy outputs return to 1 in the first cycle with no collision.
- R8: A request whose address changed since the previous cycle counts as new, just as an enable that rises does.
- R9: During reset and after it, with both ports idle, both busy outputs are 1 and both inhibits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lft_en | input | 1 | Left port enable |
| lft_addr | input | ADDR_W | Left port address |
| lft_we | input | 1 | Left port write request |
| rgt_en | input | 1 | Right port enable |
| rgt_addr | input | ADDR_W | Right port address |
| rgt_we | input | 1 | Right port write request |
| lft_busy_n | output | 1 | Left busy, active low |
| rgt_busy_n | output | 1 | Right busy, active low |
| lft_inhibit | output | 1 | Left write inhibit for the memory |
| rgt_inhibit | output | 1 | Right write inhibit for the memory |
| lft_we_gated | output | 1 | Left write after suppression |
| rgt_we_gated | output | 1 | Right write after suppression |

## Verification
The arbitration is exercised with four kinds of input:
- Requests on mismatched addresses, and matched addresses with one port disabled. These separate a true collision from a plain address match.
- A left-first arrival and a right-first arrival. These show that the later port is the one flagged, not a fixed port.
- A same-cycle arrival. This isolates the tie rule.
- A sequence in which a port moves its address onto the other port's address, and a sequence in which the winner drops its request and then re-enters. These show that an address change counts as arrival, and that the decision is held only for as long as one collision lasts.

// File: rtl/ca_pkg.sv
package ca_pkg;

    typedef enum logic [1:0] {
        OWN_NONE  = 2'd0,
        OWN_LEFT  = 2'd1,
        OWN_RIGHT = 2'd2
    } owner_e;

    typedef struct packed {
        owner_e owner;
        logic   armed;
    } core_state_t;

endpackage

// File: rtl/ca_arrival.sv
module ca_arrival #(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [ADDR_W-1:0] addr,
    output logic              fresh
);

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
    } req_t;

    req_t req_d, req_q;

    always_comb begin
        req_d.valid = en;
        req_d.addr  = addr;
        fresh = en && (!req_q.valid || (req_q.addr != addr));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= '0;
        end else begin
            req_q <= req_d;
        end
    end

    // R8: a present request that is not new matches the previous cycle's request
    assert_old_request_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !fresh) |-> (req_q.valid && req_q.addr == addr));

endmodule

// File: rtl/ca_core.sv
module ca_core
    import ca_pkg::*;
#(
    parameter int ADDR_W      = 11,
    parameter bit TIE_TO_LEFT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_en,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic              l_fresh,
    input  logic              r_en,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic              r_fresh,
    output logic              l_busy,
    output logic              r_busy
);

    owner_e      tie_pick;
    core_state_t st_d, st_q;
    logic        collide;

    generate
        if (TIE_TO_LEFT) begin : g_tie_left
            assign tie_pick = OWN_LEFT;
        end else begin : g_tie_right
            assign tie_pick = OWN_RIGHT;
        end
    endgenerate

    always_comb begin
        collide = l_en && r_en && (l_addr == r_addr);
        st_d.armed = 1'b1;
        if (!collide) begin
            st_d.owner = OWN_NONE;
        end else if (st_q.owner != OWN_NONE) begin
            st_d.owner = st_q.owner;
        end else if (l_fresh && !r_fresh) begin
            st_d.owner = OWN_RIGHT;
        end else if (r_fresh && !l_fresh) begin
            st_d.owner = OWN_LEFT;
        end else begin
            st_d.owner = tie_pick;
        end
        l_busy = collide && (st_d.owner == OWN_RIGHT);
        r_busy = collide && (st_d.owner == OWN_LEFT);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.owner <= OWN_NONE;
            st_q.armed <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assert_never_both_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(l_busy && r_busy));

    assert_no_busy_without_match_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (l_addr != r_addr) |-> (!l_busy && !r_busy));

    assert_no_busy_when_disabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!l_en || !r_en) |-> (!l_busy && !r_busy));

    assert_later_left_flagged_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (l_en && r_en && l_addr == r_addr && st_q.owner == OWN_NONE && l_fresh && !r_fresh)
        |-> (l_busy && !r_busy));

    assert_tie_rule_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (TIE_TO_LEFT && l_en && r_en && l_addr == r_addr && st_q.owner == OWN_NONE
         && l_fresh && r_fresh) |-> (r_busy && !l_busy));

    assert_flag_persists_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.armed && l_en && r_en && l_addr == r_addr && $past(l_en && r_en && l_addr == r_addr))
        |-> (l_busy == $past(l_busy) && r_busy == $past(r_busy)));

endmodule

// File: rtl/collision_arbiter.sv
module collision_arbiter #(
    parameter int ADDR_W      = 11,
    parameter bit TIE_TO_LEFT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lft_en,
    input  logic [ADDR_W-1:0] lft_addr,
    input  logic              lft_we,
    input  logic              rgt_en,
    input  logic [ADDR_W-1:0] rgt_addr,
    input  logic              rgt_we,
    output logic              lft_busy_n,
    output logic              rgt_busy_n,
    output logic              lft_inhibit,
    output logic              rgt_inhibit,
    output logic              lft_we_gated,
    output logic              rgt_we_gated
);

    localparam int NPORT = 2;

    logic              en_a    [NPORT];
    logic [ADDR_W-1:0] addr_a  [NPORT];
    logic              we_a    [NPORT];
    logic              fresh_a [NPORT];
    logic              busy_a  [NPORT];
    logic              gated_a [NPORT];

    assign en_a[0]   = lft_en;
    assign en_a[1]   = rgt_en;
    assign addr_a[0] = lft_addr;
    assign addr_a[1] = rgt_addr;
    assign we_a[0]   = lft_we;
    assign we_a[1]   = rgt_we;

    generate
        for (genvar p = 0; p < NPORT; p++) begin : g_port
            ca_arrival #(.ADDR_W(ADDR_W)) u_arrival (
                .clk   (clk),
                .rst_n (rst_n),
                .en    (en_a[p]),
                .addr  (addr_a[p]),
                .fresh (fresh_a[p])
            );
            assign gated_a[p] = we_a[p] && !busy_a[p];
        end
    endgenerate

    ca_core #(.ADDR_W(ADDR_W), .TIE_TO_LEFT(TIE_TO_LEFT)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .l_en    (en_a[0]),
        .l_addr  (addr_a[0]),
        .l_fresh (fresh_a[0]),
        .r_en    (en_a[1]),
        .r_addr  (addr_a[1]),
        .r_fresh (fresh_a[1]),
        .l_busy  (busy_a[0]),
        .r_busy  (busy_a[1])
    );

    assign lft_busy_n   = !busy_a[0];
    assign rgt_busy_n   = !busy_a[1];
    assign lft_inhibit  = busy_a[0];
    assign rgt_inhibit  = busy_a[1];
    assign lft_we_gated = gated_a[0];
    assign rgt_we_gated = gated_a[1];

    // R6: a port flagged busy never passes a write on to the memory
    assert_busy_blocks_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !lft_busy_n |-> !lft_we_gated);
    assert_busy_blocks_write_right_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !rgt_busy_n |-> !rgt_we_gated);

endmodule

// File: tb/collision_arbiter_test.sv
module collision_arbiter_test;

    localparam int AW = 11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          lft_en = 1'b0, rgt_en = 1'b0, lft_we = 1'b0, rgt_we = 1'b0;
    logic [AW-1:0] lft_addr = '0, rgt_addr = '0;
    logic          lft_busy_n, rgt_busy_n, lft_inhibit, rgt_inhibit;
    logic          lft_we_gated, rgt_we_gated;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    collision_arbiter #(.ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n),
        .lft_en(lft_en), .lft_addr(lft_addr), .lft_we(lft_we),
        .rgt_en(rgt_en), .rgt_addr(rgt_addr), .rgt_we(rgt_we),
        .lft_busy_n(lft_busy_n), .rgt_busy_n(rgt_busy_n),
        .lft_inhibit(lft_inhibit), .rgt_inhibit(rgt_inhibit),
        .lft_we_gated(lft_we_gated), .rgt_we_gated(rgt_we_gated)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    // drive on the falling edge, settle, sample before the next rising edge
    task automatic drive(input logic le, input logic [AW-1:0] la, input logic lw,
                         input logic re, input logic [AW-1:0] ra, input logic rw);
        @(negedge clk);
        lft_en = le; lft_addr = la; lft_we = lw;
        rgt_en = re; rgt_addr = ra; rgt_we = rw;
        #1;
    endtask

    // expected busy (1 = flagged) for left/right, with checks of the derived outputs
    task automatic expect_busy(input string tag, input logic lb, input logic rb);
        chk({tag, " lft_busy_n"}, lft_busy_n, !lb);
        chk({tag, " rgt_busy_n"}, rgt_busy_n, !rb);
        chk({tag, " R6 lft_inhibit"}, lft_inhibit, lb);
        chk({tag, " R6 rgt_inhibit"}, rgt_inhibit, rb);
        chk({tag, " R6 lft_we_gated"}, lft_we_gated, lft_we && !lb);
        chk({tag, " R6 rgt_we_gated"}, rgt_we_gated, rgt_we && !rb);
        chk({tag, " R5 not both busy"}, !lft_busy_n && !rgt_busy_n, 1'b0);
    endtask

    task automatic idle();
        drive(0, '0, 0, 0, '0, 0);
    endtask

    task automatic t_reset();
        #1;
        expect_busy("R9 in reset", 0, 0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        idle();
        expect_busy("R9 after reset", 0, 0);
    endtask

    task automatic t_mismatch();
        idle();
        drive(1, 11'h005, 1, 1, 11'h006, 1);
        expect_busy("R1 mismatch", 0, 0);
        drive(1, 11'h7FF, 1, 1, 11'h000, 1);
        expect_busy("R1 mismatch extremes", 0, 0);
    endtask

    task automatic t_one_disabled();
        idle();
        drive(1, 11'h009, 1, 0, 11'h009, 1);
        expect_busy("R2 right disabled", 0, 0);
        drive(0, 11'h009, 1, 1, 11'h009, 1);
        expect_busy("R2 left disabled", 0, 0);
    endtask

    task automatic t_left_first();
        idle();
        drive(1, 11'h010, 1, 0, 11'h010, 0);
        expect_busy("R3 left alone", 0, 0);
        drive(1, 11'h010, 1, 1, 11'h010, 1);
        expect_busy("R3 right arrives later", 0, 1);
        drive(1, 11'h010, 1, 1, 11'h010, 1);
        expect_busy("R7 collision held", 0, 1);
        drive(1, 11'h010, 1, 0, 11'h010, 1);
        expect_busy("R7 released", 0, 0);
    endtask

    task automatic t_right_first();
        idle();
        drive(0, 11'h3A0, 0, 1, 11'h3A0, 1);
        expect_busy("R3 right alone", 0, 0);
        drive(1, 11'h3A0, 1, 1, 11'h3A0, 1);
        expect_busy("R3 left arrives later", 1, 0);
        drive(1, 11'h3A1, 1, 1, 11'h3A0, 1);
        expect_busy("R7 released on mismatch", 0, 0);
    endtask

    task automatic t_same_cycle();
        idle();
        drive(1, 11'h044, 1, 1, 11'h044, 1);
        expect_busy("R4 tie", 0, 1);
        drive(1, 11'h044, 0, 1, 11'h044, 0);
        expect_busy("R4 tie held", 0, 1);
    endtask

    task automatic t_addr_change();
        idle();
        drive(1, 11'h020, 1, 1, 11'h021, 1);
        expect_busy("R8 apart", 0, 0);
        drive(1, 11'h020, 1, 1, 11'h020, 1);
        expect_busy("R8 right moves onto left", 0, 1);
        idle();
        drive(1, 11'h030, 1, 1, 11'h031, 1);
        drive(1, 11'h031, 1, 1, 11'h031, 1);
        expect_busy("R8 left moves onto right", 1, 0);
    endtask

    task automatic t_rejoin();
        idle();
        drive(0, 11'h155, 0, 1, 11'h155, 0);
        drive(1, 11'h155, 1, 1, 11'h155, 0);
        expect_busy("R3 left later", 1, 0);
        for (int i = 0; i < 3; i++) begin
            drive(1, 11'h155, 1, 1, 11'h155, 1);
            expect_busy("R7 winner keeps word", 1, 0);
        end
        drive(1, 11'h155, 1, 0, 11'h155, 1);
        expect_busy("R7 winner leaves", 0, 0);
        drive(1, 11'h155, 1, 1, 11'h155, 1);
        expect_busy("R8 former winner now later", 0, 1);
    endtask

    initial begin
        t_reset();
        t_mismatch();
        t_one_disabled();
        t_left_first();
        t_right_first();
        t_same_cycle();
        t_addr_change();
        t_rejoin();
        idle();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule